// File: doc/BRIEF.md
# SPI Flash Command Engine

A byte-wide register window lets a host drive one short serial-flash command at a time over a four-wire SPI link. The host first loads an opcode, up to three address bytes and one optional trailing data byte into their registers. It then writes a start code to the control register. The engine lowers chip select and shifts the selected bytes out MSB first in SPI mode 0. It then clocks in up to three response bytes and raises chip select again.

While the engine works, bit 7 of the control/status register reads 1. Once that bit reads 0, the response bytes can be read at offsets 5, 6 and 7. A 2-bit code sets the write length, which can only be 1, 2, 4 or 5 bytes. The address registers sit at offsets in the reverse of their order on the wire. Two start codes select a slow or a fast SPI clock. Both clocks are derived from the system clock by a divider.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, busy is 0, cs_n is 1, sck is 0, and offsets 0, 5, 6 and 7 read 0x00.
- R2: A start is accepted when the control register is written while idle. From the cycle after that write, busy (and bit 7 of offset 0) is 1. It returns to 0 exactly one system cycle after cs_n rises.
- R3: On the wire, the opcode (offset 1) goes first. The address bytes follow in the order offset 4, offset 3, offset 2. Each byte is sent MSB first.
- R4: Control bits [1:0] select the write phase. Code 0 sends the opcode only. Code 1 sends the opcode, then the offset-7 byte. Code 2 sends the opcode and three address bytes. Code 3 sends the opcode, three address bytes and then the offset-7 byte. The number of sck rising edges equals 8 × (write bytes + read bytes).
- R5: Control bits [3:2] give the number n (0 to 3) of bytes read after the write phase. These bytes are sampled MSB first on sck rising edges. In arrival order they appear at offsets 5, 6 and 7 once busy clears.
- R6: Read-back offsets with an index at or above n keep their previous values.
- R7: A control value with bits [7:4] = 0x4 starts at the slow clock: the sck period is 2·HALF_SLOW system cycles. A value of 0x5 starts at the fast clock, with a period of HALF_SLOW system cycles.
- R8: SPI mode 0 applies. mosi changes only while sck is low, and sck idles low.
- R9: A control write while busy is ignored. A control write whose bits [7:4] are not 0x4 or 0x5 is also ignored. Neither one starts a transfer or changes the value read at offset 0, whose bits [6:0] echo the last accepted start code.
- R10: cs_n stays low from before the first sck edge until the last sck falling edge, and sck is low whenever cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |

## Verification
The bench builds the engine with HALF_SLOW = 6. The slow clock then has a 12-cycle period and the fast clock a 6-cycle period with an odd half-period of 3. This tests the divider at both parities, and a full 64-bit transfer still takes under 800 cycles. With this short period, dozens of random transfers fit in the run, covering every write-length code, every read count and both speeds. Directed cases add a control write in the middle of a transfer, an invalid start nibble, and a zero-read transfer after a three-byte read.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

  typedef struct packed {
    logic       fast;
    logic [1:0] wcode;
    logic [1:0] rcnt;
    logic [7:0] op;
    logic [7:0] a4;
    logic [7:0] a3;
    logic [7:0] a2;
    logic [7:0] dat;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} st_t;

  // bytes sent in the write phase for a length code
  function automatic logic [2:0] wr_len(input logic [1:0] code);
    case (code)
      2'd0:    wr_len = 3'd1;
      2'd1:    wr_len = 3'd2;
      2'd2:    wr_len = 3'd4;
      default: wr_len = 3'd5;
    endcase
  endfunction

  // MSB-aligned outgoing bit stream
  function automatic logic [39:0] build_frame(input cmd_t c);
    case (c.wcode)
      2'd0:    build_frame = {c.op, 32'h0};
      2'd1:    build_frame = {c.op, c.dat, 24'h0};
      2'd2:    build_frame = {c.op, c.a4, c.a3, c.a2, 8'h0};
      default: build_frame = {c.op, c.a4, c.a3, c.a2, c.dat};
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_clkgen.sv
`timescale 1ns/1ps
module spi_cmd_clkgen #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        busy,
  output logic        start,
  output cmd_t        cmd,
  input  logic        done,
  input  logic [1:0]  done_rcnt,
  input  logic [23:0] rx
);
  logic [7:0] op_q, a2_q, a3_q, a4_q, dat_q;
  logic [6:0] ctl_q;
  logic [7:0] rb_q [3];

  assign start = we && (addr == 3'd0) && !busy && (wdata[7:5] == 3'b010);

  always_comb begin
    cmd.fast  = wdata[4];
    cmd.rcnt  = wdata[3:2];
    cmd.wcode = wdata[1:0];
    cmd.op    = op_q;
    cmd.a4    = a4_q;
    cmd.a3    = a3_q;
    cmd.a2    = a2_q;
    cmd.dat   = dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; a2_q <= '0; a3_q <= '0; a4_q <= '0; dat_q <= '0; ctl_q <= '0;
    end else begin
      if (start) ctl_q <= wdata[6:0];
      if (we) begin
        case (addr)
          3'd1: op_q  <= wdata;
          3'd2: a2_q  <= wdata;
          3'd3: a3_q  <= wdata;
          3'd4: a4_q  <= wdata;
          3'd7: dat_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  // byte k of n arrived k-th; the first byte sits highest in rx
  for (genvar k = 0; k < 3; k++) begin : g_rb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rb_q[k] <= '0;
      else if (done && (k < int'(done_rcnt)))
        rb_q[k] <= rx[8*(int'(done_rcnt)-1-k) +: 8];
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = {busy, ctl_q};
      3'd1:    rdata = op_q;
      3'd2:    rdata = a2_q;
      3'd3:    rdata = a3_q;
      3'd4:    rdata = a4_q;
      3'd5:    rdata = rb_q[0];
      3'd6:    rdata = rb_q[1];
      default: rdata = rb_q[2];
    endcase
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
`timescale 1ns/1ps
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int HALF_SLOW = 4,
  parameter int CW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  cmd_t          cmd,
  input  logic          tick,
  output logic          run,
  output logic [CW-1:0] half,
  output logic          busy,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso,
  output logic          done,
  output logic [1:0]    done_rcnt,
  output logic [23:0]   rx
);
  localparam logic [CW-1:0] H_SLOW = CW'(HALF_SLOW);
  localparam logic [CW-1:0] H_FAST = CW'(HALF_SLOW / 2);

  st_t         st;
  logic [39:0] frame;
  logic [6:0]  bitcnt, total, nwb;
  logic        last_bit;

  assign run       = (st == ST_SHIFT);
  assign busy      = (st != ST_IDLE);
  assign mosi      = frame[39];
  assign last_bit  = (bitcnt == total - 7'd1);
  assign done      = run && tick && sck && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; frame <= '0; bitcnt <= '0; total <= '0; nwb <= '0;
      half <= H_SLOW; sck <= 1'b0; cs_n <= 1'b1; rx <= '0; done_rcnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st        <= ST_SHIFT;
          frame     <= build_frame(cmd);
          nwb       <= {1'b0, wr_len(cmd.wcode), 3'b000};
          total     <= {1'b0, wr_len(cmd.wcode), 3'b000} + {2'b00, cmd.rcnt, 3'b000};
          done_rcnt <= cmd.rcnt;
          half      <= cmd.fast ? H_FAST : H_SLOW;
          bitcnt    <= '0;
          rx        <= '0;
          cs_n      <= 1'b0;
        end
        ST_SHIFT: if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            if (bitcnt >= nwb) rx <= {rx[22:0], miso};
          end else begin
            sck <= 1'b0;
            if (last_bit) begin
              cs_n <= 1'b1;
              st   <= ST_TAIL;
            end else begin
              bitcnt <= bitcnt + 7'd1;
              frame  <= {frame[38:0], 1'b0};
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int HALF_SLOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       busy,
  output logic       sck,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = $clog2(HALF_SLOW + 1);

  cmd_t          cmd;
  logic          start_evt, tick, run, done_evt;
  logic [CW-1:0] half;
  logic [1:0]    done_rcnt;
  logic [23:0]   rx;

  spi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .start(start_evt), .cmd(cmd),
    .done(done_evt), .done_rcnt(done_rcnt), .rx(rx)
  );

  spi_cmd_clkgen #(.CW(CW)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half), .tick(tick)
  );

  spi_cmd_shifter #(.HALF_SLOW(HALF_SLOW), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .cmd(cmd), .tick(tick),
    .run(run), .half(half), .busy(busy), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .done(done_evt), .done_rcnt(done_rcnt), .rx(rx)
  );
endmodule

// File: rtl/spi_cmd_checker.sv
`timescale 1ns/1ps
module spi_cmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic       start_evt,
  input logic       busy,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi
);
  a_r2_busy_covers_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  a_r2_busy_drops_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> busy ##1 !busy);
  a_r9_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 3'd0) |-> !start_evt);
  a_r10_start_lowers_cs: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && !cs_n && !sck));
  a_r10_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  a_r10_rise_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> !cs_n);
  a_r8_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

bind spi_cmd_engine spi_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .start_evt(start_evt), .busy(busy), .sck(sck), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/test_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_cmd_engine;
  localparam int HS = 6;

  logic clk = 0, rst_n = 0, reg_we = 0, miso;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic busy, sck, cs_n, mosi;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spi_cmd_engine #(.HALF_SLOW(HS)) i_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  // flash responder model
  logic [63:0] stream = 0, cap = 0;
  int ridx = 0, npos = 0;
  time t1, t2, t_csr, t_bf;
  assign miso = (ridx < 64) ? stream[63-ridx] : 1'b0;
  always @(negedge cs_n) ridx = 0;
  always @(negedge sck) if (!cs_n) ridx++;
  always @(posedge sck) begin
    if (npos < 64) cap[63-npos] = mosi;
    if (npos == 0) t1 = $time;
    if (npos == 1) t2 = $time;
    npos++;
  end
  always @(posedge cs_n) t_csr = $time;
  always @(negedge busy) t_bf = $time;

  logic [7:0] exp_rb [3];
  logic [6:0] exp_ctl;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic int nbytes(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : 5;
  endfunction

  // wire-order image of the write phase, MSB aligned in 64 bits
  function automatic logic [63:0] wire_img(input logic [1:0] c, input logic [7:0] op,
      input logic [7:0] w1, input logic [7:0] w2, input logic [7:0] w3, input logic [7:0] dat);
    logic [63:0] v = {op, 56'h0};
    if (c >= 2) v[55:32] = {w1, w2, w3};
    if (c == 1) v[55:48] = dat;
    if (c == 3) v[31:24] = dat;
    return v;
  endfunction

  task automatic txn(input logic [1:0] wc, input logic [1:0] rc, input bit fast,
      input logic [7:0] op, input logic [7:0] w1, input logic [7:0] w2, input logic [7:0] w3,
      input logic [7:0] dat, input logic [23:0] resp, input bit poke);
    logic [7:0] d;
    logic [63:0] mask;
    int nw = nbytes(wc), n = 0;
    wr(1, op); wr(4, w1); wr(3, w2); wr(2, w3); wr(7, dat);
    stream = {resp, 40'h0} >> (8*nw);
    cap = 0; npos = 0;
    wr(0, {3'b010, fast, rc, wc});
    exp_ctl = {2'b10, fast, rc, wc};
    chk(busy && !cs_n, "R2 busy after start", {busy, cs_n}, 2'b10);
    if (poke) begin
      repeat (10) @(negedge clk);
      wr(0, 8'h5F);  // must be ignored (R9)
    end
    while (busy && n < 2000) begin @(negedge clk); n++; end
    chk(!busy, "R2 busy clears", busy, 0);
    chk(t_bf - t_csr == 20, "R2 busy one cycle after cs rise", t_bf - t_csr, 20);
    chk(npos == 8*(nw+rc), "R4 sck edge count", npos, 8*(nw+rc));
    mask = ~(64'hFFFF_FFFF_FFFF_FFFF >> (8*nw));
    chk((cap & mask) == wire_img(wc, op, w1, w2, w3, dat), "R3/R4 wire bytes",
        cap & mask, wire_img(wc, op, w1, w2, w3, dat));
    chk(t2 - t1 == (fast ? HS : 2*HS) * 20, "R7 sck period", t2 - t1, (fast ? HS : 2*HS) * 20);
    for (int k = 0; k < 3; k++) if (k < rc) exp_rb[k] = resp[23-8*k -: 8];
    for (int k = 0; k < 3; k++) begin
      rd(3'(5+k), d);
      chk(d == exp_rb[k], (k < rc) ? "R5 readback byte" : "R6 readback kept", d, exp_rb[k]);
    end
    rd(0, d);
    chk(d == {1'b0, exp_ctl}, "R9 status echoes accepted start", d, {1'b0, exp_ctl});
    chk(cs_n && !sck, "R10 idle lines", {cs_n, sck}, 2'b10);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 3; k++) exp_rb[k] = 0;
    exp_ctl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && cs_n && !sck, "R1 reset lines", {busy, cs_n, sck}, 3'b010);
    for (int a = 0; a < 8; a++) begin
      if (a >= 1 && a <= 4) continue;
      rd(3'(a), d);
      chk(d == 0, "R1 reset register", d, 0);
    end
    // directed corners
    txn(2, 3, 0, 8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 24'hA5C33C, 0);
    txn(0, 0, 1, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00, 24'hFFFFFF, 0);   // R6 all kept
    txn(1, 1, 0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h9E, 24'h81FFFF, 1);   // R9 mid poke
    txn(3, 2, 1, 8'h02, 8'hAB, 8'hCD, 8'hEF, 8'h77, 24'h5A0F00, 1);
    // R9 invalid start nibble while idle
    npos = 0;
    wr(0, 8'h3D);
    repeat (30) @(negedge clk);
    chk(!busy && cs_n && npos == 0, "R9 invalid nibble ignored", {busy, cs_n, 8'(npos)}, 10'h100);
    rd(0, d);
    chk(d == {1'b0, exp_ctl}, "R9 status kept after invalid", d, {1'b0, exp_ctl});
    // random mix
    for (int i = 0; i < 40; i++)
      txn(2'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
          8'($urandom), 8'($urandom), 8'($urandom), 24'($urandom), (i % 7) == 3);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule